// File: doc/BRIEF.md
# Acknowledgement Wait Timeout Controller

After the transmitter finishes sending a unicast frame, this block decides whether the peer's acknowledgement came back in time. The wait has two phases. In the first phase it waits for the receive chain to report a detected PHY header. Once a header is seen, the second phase waits for the decoder to report that decoding has finished. Each phase has its own limit, counted in units of 0.1 us. A prescaler turns the core clock into those units (ten cycles at 100 MHz by default).

Two configuration words are held on chip, one for the 2.4 GHz band and one for the 5 GHz band. The band input selects the word to use when the transmission ends, and that word is captured for the whole wait. Each word also carries a flag that decides whether the acknowledgement needs a valid FCS to be accepted. At the end of every wait the block reports pass or fail, raises a retry indication when it fails, and keeps a saturating count of consecutive failures.

Top module: `ack_wait_ctrl`

## Requirements
- R1: After a synchronous reset, busy, res_valid, res_pass, res_retry and retry_cnt are all 0, and both band words hold the default: header limit 565 units, decode limit 10 units, FCS required.
- R2: Limits count units of TICK_DIV clock cycles. A phase with limit L times out in the cycle that starts L*TICK_DIV cycles after the phase was entered, where cycle 0 is the first cycle in the phase.
- R3: If no header is detected by the header-phase timeout, the wait ends as a failure.
- R4: A header detected in the same cycle that the header timer expires counts as detected, and the decode phase begins.
- R5: After a header, if decoding does not finish by the decode-phase timeout, the wait ends as a failure.
- R6: When the captured word has bit 31 set, a decoded matching ACK passes only if fcs_ok is high in the decode-done cycle. When bit 31 is clear, fcs_ok is ignored.
- R7: A decode-done with ack_match low ends the wait as a failure.
- R8: A configuration word is written with cfg_we, and cfg_band picks its band (0 = 2.4 GHz, 1 = 5 GHz). Bits [14:0] hold the decode limit and bits [30:16] hold the header limit. band_sel sampled with tx_done picks the word for that wait.
- R9: The band word is captured when tx_done is accepted. A write during a wait changes only later waits.
- R10: A failure increments retry_cnt, which saturates at its maximum. A pass clears it. res_retry is high with a failed result and low with a passing one.
- R11: tx_done is ignored while a wait is in progress and in the cycle the result is shown.
- R12: res_valid is high for exactly one cycle, the cycle after the deciding cycle, with res_pass, res_retry and retry_cnt valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| band_sel | input | BAND_W | Band of the frame just sent (0 = 2.4 GHz, 1 = 5 GHz) |
| tx_done | input | 1 | Pulse marking the end of a unicast transmission |
| hdr_det | input | 1 | Receive chain reports a PHY header |
| dec_done | input | 1 | Decoder reports a finished frame |
| fcs_ok | input | 1 | FCS of the decoded frame is valid |
| ack_match | input | 1 | Decoded frame is the expected ACK |
| cfg_we | input | 1 | Write strobe for a band word |
| cfg_band | input | BAND_W | Band whose word is written |
| cfg_wdata | input | 32 | Band word: [31] FCS required, [30:16] header limit, [14:0] decode limit |
| busy | output | 1 | A wait phase is in progress |
| res_valid | output | 1 | Result strobe |
| res_pass | output | 1 | ACK accepted |
| res_retry | output | 1 | Retransmission needed |
| retry_cnt | output | RETRY_W | Consecutive failures, saturating |

## Verification
The bench goes after the exact expiry cycle of each phase. A counter that is off by one unit or one cycle shows up as a result one cycle early or late. It drives a header on the very cycle the header timer expires, and a design that gives the timeout priority would report a failure there instead of a pass. It exercises both settings of the FCS flag across both bands, so a design that reads the flag from the wrong band word would pass a frame with a bad FCS. It writes a band word in the middle of a wait, and a design that does not capture the word would stretch the current wait. It also drives enough failures to saturate the counter, and a counter without saturation would wrap to zero.

// File: rtl/ack_wait_pkg.sv
package ack_wait_pkg;

  localparam int CFG_W   = 32;
  localparam int LIM_W   = 15;
  localparam int DEC_LSB = 0;
  localparam int HDR_LSB = 16;
  localparam int FCS_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HDR,
    ST_WAIT_DEC,
    ST_DONE
  } wait_state_t;

  typedef struct packed {
    logic             fcs_req;
    logic [LIM_W-1:0] hdr_lim;
    logic [LIM_W-1:0] dec_lim;
  } wait_cfg_t;

  function automatic wait_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    wait_cfg_t c;
    c.fcs_req = w[FCS_BIT];
    c.hdr_lim = w[HDR_LSB +: LIM_W];
    c.dec_lim = w[DEC_LSB +: LIM_W];
    return c;
  endfunction

endpackage

// File: rtl/ack_tick_gen.sv
module ack_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre <= '0;
    end else if (tick) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R2: two unit ticks never fall on neighbouring cycles
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ack_phase_timer.sv
module ack_phase_timer #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the unit count never runs past the limit of its phase
  a_r3_within_limit: assert property (@(posedge clk) disable iff (rst)
    (!clear && cnt <= limit) |=> (cnt <= $past(limit)));

endmodule

// File: rtl/ack_cfg_bank.sv
module ack_cfg_bank
  import ack_wait_pkg::*;
#(
  parameter int NUM_BANDS   = 2,
  parameter int BAND_W      = 1,
  parameter int HDR_DEFAULT = 565,
  parameter int DEC_DEFAULT = 10,
  parameter bit FCS_DEFAULT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BAND_W-1:0] wband,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [BAND_W-1:0] rband,
  output wait_cfg_t         rcfg
);
  localparam wait_cfg_t DEF = '{fcs_req: FCS_DEFAULT,
                                hdr_lim: LIM_W'(HDR_DEFAULT),
                                dec_lim: LIM_W'(DEC_DEFAULT)};

  wait_cfg_t bank [NUM_BANDS];

  generate
    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      always_ff @(posedge clk) begin
        if (rst) begin
          bank[b] <= DEF;
        end else if (we && (wband == BAND_W'(b))) begin
          bank[b] <= unpack_cfg(wdata);
        end
      end
    end
  endgenerate

  always_comb begin
    rcfg = bank[0];
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (rband == BAND_W'(b)) rcfg = bank[b];
    end
  end

endmodule

// File: rtl/ack_wait_ctrl.sv
module ack_wait_ctrl
  import ack_wait_pkg::*;
#(
  parameter int TICK_DIV    = 10,
  parameter int NUM_BANDS   = 2,
  parameter int RETRY_W     = 4,
  parameter int HDR_DEFAULT = 565,
  parameter int DEC_DEFAULT = 10,
  parameter bit FCS_DEFAULT = 1'b1,
  localparam int BAND_W     = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BAND_W-1:0]  band_sel,
  input  logic               tx_done,
  input  logic               hdr_det,
  input  logic               dec_done,
  input  logic               fcs_ok,
  input  logic               ack_match,
  input  logic               cfg_we,
  input  logic [BAND_W-1:0]  cfg_band,
  input  logic [31:0]        cfg_wdata,
  output logic               busy,
  output logic               res_valid,
  output logic               res_pass,
  output logic               res_retry,
  output logic [RETRY_W-1:0] retry_cnt
);
  localparam logic [RETRY_W-1:0] RETRY_MAX = '1;

  wait_state_t      state, nxt;
  wait_cfg_t        cfg_rd, snap;
  logic             tick, expired, start, decide, ok;
  logic [LIM_W-1:0] limit;

  ack_cfg_bank #(
    .NUM_BANDS  (NUM_BANDS),
    .BAND_W     (BAND_W),
    .HDR_DEFAULT(HDR_DEFAULT),
    .DEC_DEFAULT(DEC_DEFAULT),
    .FCS_DEFAULT(FCS_DEFAULT)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wband(cfg_band),
    .wdata(cfg_wdata),
    .rband(band_sel),
    .rcfg (cfg_rd)
  );

  ack_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .restart(start),
    .tick   (tick)
  );

  assign limit = (state == ST_WAIT_DEC) ? snap.dec_lim : snap.hdr_lim;

  ack_phase_timer #(.W(LIM_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .tick   (tick),
    .limit  (limit),
    .expired(expired)
  );

  always_comb begin
    nxt    = state;
    start  = 1'b0;
    decide = 1'b0;
    ok     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (tx_done) begin
          nxt   = ST_WAIT_HDR;
          start = 1'b1;
        end
      end
      ST_WAIT_HDR: begin
        if (hdr_det) begin
          nxt   = ST_WAIT_DEC;
          start = 1'b1;
        end else if (expired) begin
          nxt    = ST_DONE;
          decide = 1'b1;
        end
      end
      ST_WAIT_DEC: begin
        if (dec_done) begin
          nxt    = ST_DONE;
          decide = 1'b1;
          ok     = ack_match && (fcs_ok || !snap.fcs_req);
        end else if (expired) begin
          nxt    = ST_DONE;
          decide = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      snap  <= '0;
    end else begin
      state <= nxt;
      busy  <= (nxt == ST_WAIT_HDR) || (nxt == ST_WAIT_DEC);
      if (state == ST_IDLE && tx_done) snap <= cfg_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_retry <= 1'b0;
      retry_cnt <= '0;
    end else if (decide) begin
      res_valid <= 1'b1;
      res_pass  <= ok;
      res_retry <= !ok;
      if (ok)                          retry_cnt <= '0;
      else if (retry_cnt != RETRY_MAX) retry_cnt <= retry_cnt + 1'b1;
    end else begin
      res_valid <= 1'b0;
      res_retry <= 1'b0;
    end
  end

  // R12: the result strobe lasts a single cycle
  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R10: a passing result leaves the failure count at zero
  a_r10_pass_clears: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_pass) |-> (retry_cnt == '0));

  // R10: retry request accompanies exactly the failing results
  a_r10_retry_on_fail: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_retry != res_pass));

  // R4: a header always moves the wait to decoding, even at expiry
  a_r4_hdr_wins: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_HDR && hdr_det) |=> (state == ST_WAIT_DEC && !res_valid));

  // R6: with FCS required, a bad FCS never passes
  a_r6_fcs_enforced: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_DEC && dec_done && snap.fcs_req && !fcs_ok) |=> (res_valid && !res_pass));

  // R9: the captured word holds for the whole wait
  a_r9_snap_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(snap));

  // R11: the result cycle always returns to idle
  a_r11_done_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE && !busy));

endmodule

// File: tb/ack_wait_ctrl_tb.sv
module ack_wait_ctrl_tb;
  localparam int DIV = 10;
  localparam int RMAX = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [0:0]  band_sel = '0;
  logic        tx_done = 0, hdr_det = 0, dec_done = 0, fcs_ok = 0, ack_match = 0;
  logic        cfg_we = 0;
  logic [0:0]  cfg_band = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, res_valid, res_pass, res_retry;
  logic [3:0]  retry_cnt;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ack_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .band_sel(band_sel), .tx_done(tx_done),
    .hdr_det(hdr_det), .dec_done(dec_done), .fcs_ok(fcs_ok), .ack_match(ack_match),
    .cfg_we(cfg_we), .cfg_band(cfg_band), .cfg_wdata(cfg_wdata),
    .busy(busy), .res_valid(res_valid), .res_pass(res_pass),
    .res_retry(res_retry), .retry_cnt(retry_cnt)
  );

  // behavioural reference model
  int m_state, m_el, m_hl, m_dl, m_fr, m_cnt;
  int m_h [2], m_d [2], m_f [2];
  bit m_valid, m_pass, m_retry, m_busy, m_dec, m_ok;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_el = 0; m_cnt = 0; m_valid = 0; m_pass = 0; m_retry = 0; m_busy = 0;
      m_hl = 0; m_dl = 0; m_fr = 0;
      for (int b = 0; b < 2; b++) begin m_h[b] = 565; m_d[b] = 10; m_f[b] = 1; end
    end else begin
      m_dec = 0; m_ok = 0;
      case (m_state)
        0: begin
          m_valid = 0; m_retry = 0;
          if (tx_done) begin
            m_hl = m_h[band_sel]; m_dl = m_d[band_sel]; m_fr = m_f[band_sel];
            m_el = 0; m_state = 1;
          end
        end
        1: if (hdr_det) begin m_state = 2; m_el = 0; end
           else if (m_el >= m_hl * DIV) m_dec = 1;
           else m_el++;
        2: if (dec_done) begin m_dec = 1; m_ok = ack_match && (fcs_ok || m_fr == 0); end
           else if (m_el >= m_dl * DIV) m_dec = 1;
           else m_el++;
        default: begin m_valid = 0; m_retry = 0; m_state = 0; end
      endcase
      if (m_dec) begin
        m_valid = 1; m_pass = m_ok; m_retry = !m_ok; m_state = 3;
        if (m_ok) m_cnt = 0; else if (m_cnt < RMAX) m_cnt++;
      end
      if (cfg_we) begin
        m_f[cfg_band] = cfg_wdata[31];
        m_h[cfg_band] = int'(cfg_wdata[30:16]);
        m_d[cfg_band] = int'(cfg_wdata[14:0]);
      end
      m_busy = (m_state == 1 || m_state == 2);
    end
  end

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(res_valid == m_valid, "R12", "model res_valid", res_valid, m_valid);
      chk(res_retry == m_retry, "R10", "model res_retry", res_retry, m_retry);
      chk(busy == m_busy, "R11", "model busy", busy, m_busy);
      chk(int'(retry_cnt) == m_cnt, "R10", "model retry_cnt", retry_cnt, m_cnt);
      if (m_valid) chk(res_pass == m_pass, "R12", "model res_pass", res_pass, m_pass);
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  task automatic write_cfg(input int band, input logic [31:0] data);
    cfg_we = 1; cfg_band = 1'(band); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one wait: tx_done, then header/decode events at cycle offsets from the
  // first cycle of the header phase; checks decision cycle and results
  task automatic run(input int band, input int hdr_at, input int dec_at,
                     input bit match, input bit fcs, input int again_at,
                     input int wr_at, input logic [31:0] wr_data,
                     input int exp_c, input bit exp_pass, input int exp_cnt,
                     input string tag);
    int c;
    band_sel = 1'(band);
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    c = 0;
    while (1) begin
      hdr_det   = (c == hdr_at);
      dec_done  = (dec_at >= 0) && (c == hdr_at + 1 + dec_at);
      ack_match = match;
      fcs_ok    = fcs;
      tx_done   = (c == again_at);
      cfg_we    = (c == wr_at);
      cfg_band  = 1'b0;
      cfg_wdata = wr_data;
      @(negedge clk);
      if (res_valid || c > 10000) break;
      c++;
    end
    hdr_det = 0; dec_done = 0; cfg_we = 0;
    chk(c == exp_c, "R2", {tag, " decision cycle"}, c, exp_c);
    chk(res_pass == exp_pass, tag, "res_pass", res_pass, exp_pass);
    chk(int'(retry_cnt) == exp_cnt, "R10", {tag, " retry_cnt"}, retry_cnt, exp_cnt);
    chk(res_retry == !exp_pass, "R10", {tag, " res_retry"}, res_retry, !exp_pass);
    tx_done = 1;  // lands in the result cycle, must be dropped (R11)
    @(negedge clk);
    tx_done = 0;
    chk(res_valid == 0, "R12", {tag, " strobe width"}, res_valid, 0);
    chk(busy == 0, "R11", {tag, " tx_done in result cycle"}, busy, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && res_valid == 0 && res_pass == 0 && res_retry == 0, "R1", "reset outputs", res_valid, 0);
    chk(retry_cnt == 0, "R1", "reset retry_cnt", retry_cnt, 0);
    rst = 0;
    @(negedge clk);
    // R1/R3: default word, header timeout at 565 units
    run(0, -1, -1, 1, 1, -1, -1, 0, 565 * DIV, 0, 1, "R1");
    // R8: band words: band0 fcs=1 hdr=3 dec=2, band1 fcs=0 hdr=5 dec=4
    write_cfg(0, 32'h8003_0002);
    write_cfg(1, 32'h0005_0004);
    run(0, -1, -1, 1, 1, -1, -1, 0, 30, 0, 2, "R3");
    run(0, 30, 0, 1, 1, -1, -1, 0, 31, 1, 0, "R4");
    run(0, 5, -1, 1, 1, -1, -1, 0, 26, 0, 1, "R5");
    run(0, 2, 3, 1, 0, -1, -1, 0, 6, 0, 2, "R6");
    run(1, 2, 3, 1, 0, -1, -1, 0, 6, 1, 0, "R6");
    run(1, -1, -1, 1, 1, -1, -1, 0, 50, 0, 1, "R8");
    run(0, 1, 0, 0, 1, -1, -1, 0, 2, 0, 2, "R7");
    for (int i = 0; i < 13; i++) run(0, -1, -1, 1, 1, -1, -1, 0, 30, 0, 3 + i, "R10");
    run(0, -1, -1, 1, 1, -1, -1, 0, 30, 0, 15, "R10");
    run(1, 0, 0, 1, 0, -1, -1, 0, 1, 1, 0, "R10");
    // R9: rewrite band0 header limit to 6 mid-wait
    run(0, -1, -1, 1, 1, -1, 4, 32'h8006_0002, 30, 0, 1, "R9");
    run(0, -1, -1, 1, 1, -1, -1, 0, 60, 0, 2, "R9");
    // R11: second tx_done mid-wait is ignored
    run(1, -1, -1, 1, 1, 10, -1, 0, 50, 0, 3, "R11");
    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule